// File: doc/BRIEF.md
# Postfix Stack Arithmetic Unit

This block evaluates arithmetic expressions written in postfix (reverse Polish) order. It keeps a small operand stack inside itself. It accepts one instruction at a time over a valid/ready handshake. Only the two memory-transfer instructions carry an address. A load instruction reads a word from data memory and places it on the stack. A store instruction removes the topmost word and writes it to memory.

The arithmetic instructions name no operands. They consume the two highest stack entries and leave one result in their place. The statement `c = a + b` therefore becomes load a, load b, add, store c. Longer formulas follow the same pattern. For example, `a b c d * + * e f + /` leaves `a*(b+c*d)/(e+f)` as the only entry on the stack.

Misuse of the stack sets a sticky error flag, and so does a zero divisor. Only a reset clears that flag. The current depth and the top entry are visible on output ports.

Top module: `stack_expr_unit`

## Requirements
- R1: After reset, `depth` is 0, `err` is 0, `instr_ready` is 1 and `mem_req` is 0.
- R2: Opcode 0 (load) reads the word at `instr_addr` and places it on top, so `depth` rises by one. The unit issues one read cycle (`mem_req`=1, `mem_we`=0), and the memory returns the data on `mem_rdata` in the following cycle. `instr_ready` stays low for exactly 2 cycles after acceptance.
- R3: Opcode 1 (store) writes the top word to `instr_addr` in one write cycle (`mem_req`=1, `mem_we`=1) and removes it, so `depth` drops by one. `instr_ready` stays low for exactly 1 cycle.
- R4: Opcodes 2 (add), 3 (subtract) and 4 (multiply) combine the two top entries and replace them with one result, so `depth` drops by one. The top entry is the second operand, so subtract gives below minus top. Results keep the low DW bits. These instructions never stall.
- R5: Opcode 5 (divide) gives the unsigned quotient of below divided by top. A zero divisor yields an all-ones result and sets `err`. In both cases the stack still shrinks by one.
- R6: A load while `depth` equals DEPTH sets `err`, leaves the stack unchanged and makes no memory access.
- R7: A store on an empty stack, or an arithmetic instruction with fewer than two entries, sets `err` and leaves the stack unchanged.
- R8: `err` stays high until reset, whatever instructions follow.
- R9: Opcodes 6 and 7 are accepted and have no effect on the stack or on `err`.
- R10: The postfix program for `a*(b+c*d)/(e+f)` ends with `depth` 1 and that value on `top_data`.
- R11: While a memory access is pending, `instr_ready` is low, and an instruction held on the inputs is not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 3 | Opcode, encoded as in R2 to R9 |
| instr_addr | input | AW | Memory address for load and store |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |
| top_data | output | DW | Top entry (0 when empty) |
| err | output | 1 | Sticky error flag |

## Verification
Two effects can land on the same clock edge: a division by zero commits its all-ones result to the stack and raises the error flag in the same edge. The bench loads a non-zero dividend and a zero divisor, divides, and then checks in the next low clock phase that `depth` fell by one, that `top_data` is all ones and that `err` is high. The other case is an instruction held valid during a load stall, while the memory access is in flight. The bench holds an add on the inputs through the stall and checks that only the load took effect.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_ADD   = 3'd2;
    localparam logic [2:0] OP_SUB   = 3'd3;
    localparam logic [2:0] OP_MUL   = 3'd4;
    localparam logic [2:0] OP_DIV   = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2,
        ST_WR   = 2'd3
    } ctl_state_e;

    function automatic logic is_arith(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/sxu_alu.sv
module sxu_alu #(
    parameter int DW = 16
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] result,
    output logic          div_zero
);
    import sxu_pkg::*;

    localparam int PW = 2 * DW;

    logic [PW-1:0] product;

    always_comb begin
        product  = PW'(lhs) * PW'(rhs);
        result   = '0;
        div_zero = 1'b0;
        case (op)
            OP_ADD: result = lhs + rhs;
            OP_SUB: result = lhs - rhs;
            OP_MUL: result = product[DW-1:0];
            OP_DIV: begin
                if (rhs == '0) begin
                    result   = '1;
                    div_zero = 1'b1;
                end else begin
                    result = lhs / rhs;
                end
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/sxu_stack.sv
module sxu_stack #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic          fold_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] top_o,
    output logic [DW-1:0] below_o,
    output logic [CW-1:0] cnt_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    logic [IW-1:0] top_idx, below_idx, free_idx;

    always_comb begin
        top_idx   = IW'(stk_q.cnt - CW'(1));
        below_idx = IW'(stk_q.cnt - CW'(2));
        free_idx  = IW'(stk_q.cnt);
        top_o     = (stk_q.cnt != '0)    ? stk_q.slot[top_idx]   : '0;
        below_o   = (stk_q.cnt > CW'(1)) ? stk_q.slot[below_idx] : '0;
        cnt_o     = stk_q.cnt;

        stk_d = stk_q;
        if (push_en) begin
            stk_d.slot[free_idx] = wr_data;
            stk_d.cnt            = stk_q.cnt + CW'(1);
        end else if (pop_en) begin
            stk_d.cnt = stk_q.cnt - CW'(1);
        end else if (fold_en) begin
            stk_d.slot[below_idx] = wr_data;
            stk_d.cnt             = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

endmodule

// File: rtl/stack_expr_unit.sv
module stack_expr_unit #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int AW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_valid,
    output logic                         instr_ready,
    input  logic [2:0]                   instr_op,
    input  logic [AW-1:0]                instr_addr,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_wdata,
    input  logic [DW-1:0]                mem_rdata,
    output logic [$clog2(DEPTH+1)-1:0]   depth,
    output logic [DW-1:0]                top_data,
    output logic                         err
);
    import sxu_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ctl_state_e    state;
        logic [AW-1:0] addr;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          push_en, pop_en, fold_en, fire;
    logic [DW-1:0] wr_data, top_w, below_w, alu_res;
    logic [CW-1:0] cnt_w;
    logic          alu_dz;

    sxu_stack #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (push_en),
        .pop_en  (pop_en),
        .fold_en (fold_en),
        .wr_data (wr_data),
        .top_o   (top_w),
        .below_o (below_w),
        .cnt_o   (cnt_w)
    );

    sxu_alu #(.DW(DW)) u_alu (
        .op       (instr_op),
        .lhs      (below_w),
        .rhs      (top_w),
        .result   (alu_res),
        .div_zero (alu_dz)
    );

    always_comb begin
        ctl_d   = ctl_q;
        push_en = 1'b0;
        pop_en  = 1'b0;
        fold_en = 1'b0;
        wr_data = '0;
        fire    = instr_valid && (ctl_q.state == ST_IDLE);

        case (ctl_q.state)
            ST_IDLE: begin
                if (fire) begin
                    if (instr_op == OP_LOAD) begin
                        if (cnt_w == CW'(DEPTH)) begin
                            ctl_d.err = 1'b1;
                        end else begin
                            ctl_d.state = ST_RD;
                            ctl_d.addr  = instr_addr;
                        end
                    end else if (instr_op == OP_STORE) begin
                        if (cnt_w == '0) begin
                            ctl_d.err = 1'b1;
                        end else begin
                            ctl_d.state = ST_WR;
                            ctl_d.addr  = instr_addr;
                        end
                    end else if (is_arith(instr_op)) begin
                        if (cnt_w < CW'(2)) begin
                            ctl_d.err = 1'b1;
                        end else begin
                            fold_en = 1'b1;
                            wr_data = alu_res;
                            if (alu_dz) ctl_d.err = 1'b1;
                        end
                    end
                end
            end
            ST_RD: begin
                ctl_d.state = ST_CAP;
            end
            ST_CAP: begin
                push_en     = 1'b1;
                wr_data     = mem_rdata;
                ctl_d.state = ST_IDLE;
            end
            ST_WR: begin
                pop_en      = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, addr: '0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign instr_ready = (ctl_q.state == ST_IDLE);
    assign mem_req     = (ctl_q.state == ST_RD) || (ctl_q.state == ST_WR);
    assign mem_we      = (ctl_q.state == ST_WR);
    assign mem_addr    = ctl_q.addr;
    assign mem_wdata   = top_w;
    assign depth       = cnt_w;
    assign top_data    = top_w;
    assign err         = ctl_q.err;

endmodule

// File: rtl/sxu_checker.sv
module sxu_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic          instr_ready,
    input logic [2:0]    instr_op,
    input logic          mem_req,
    input logic          mem_we,
    input logic [CW-1:0] depth,
    input logic          err
);
    import sxu_pkg::*;

    logic fire;
    assign fire = instr_valid && instr_ready;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !instr_ready);

    // R2
    load_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && instr_op == OP_LOAD && depth < CW'(DEPTH)) |=> (mem_req && !mem_we));

    // R3
    store_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (depth == $past(depth) - CW'(1)));

    // R4
    arith_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_arith(instr_op) && depth >= CW'(2)) |=> (depth == $past(depth) - CW'(1)));

    // R6
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && instr_op == OP_LOAD && depth == CW'(DEPTH)) |=> (err && $stable(depth) && !mem_req));

endmodule

bind stack_expr_unit sxu_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_op    (instr_op),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .depth       (depth),
    .err         (err)
);

// File: tb/sim_stack_expr_unit.sv
`timescale 1ns/1ps
module sim_stack_expr_unit;
    localparam int DEPTH = 8;
    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic          instr_ready;
    logic [2:0]    instr_op = '0;
    logic [AW-1:0] instr_addr = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [CW-1:0] depth;
    logic [DW-1:0] top_data;
    logic          err;

    always #10 clk = ~clk;

    stack_expr_unit #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .depth(depth), .top_data(top_data), .err(err)
    );

    logic [DW-1:0] mem [0:(1<<AW)-1];

    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    int n_chk = 0;
    int n_fail = 0;
    int unsigned m_stk[$];
    bit m_err = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_state(input string req);
        chk(depth == CW'(m_stk.size()), req, "depth", depth, m_stk.size());
        if (m_stk.size() > 0)
            chk(top_data == DW'(m_stk[$]), req, "top", top_data, m_stk[$]);
        chk(err == m_err, req, "err", err, m_err);
    endtask

    function automatic int unsigned f_alu(input logic [2:0] op, input int unsigned a,
                                          input int unsigned b, output bit dz);
        int unsigned r;
        dz = 1'b0;
        case (op)
            3'd2: r = a + b;
            3'd3: r = a - b;
            3'd4: r = a * b;
            default: begin
                if (b == 0) begin r = 32'hFFFF; dz = 1'b1; end
                else r = a / b;
            end
        endcase
        return r & 32'hFFFF;
    endfunction

    task automatic model(input logic [2:0] op, input logic [AW-1:0] a);
        int unsigned x, y;
        bit dz;
        case (op)
            3'd0: if (m_stk.size() == DEPTH) m_err = 1'b1;
                  else m_stk.push_back(int'(mem[a]));
            3'd1: if (m_stk.size() == 0) m_err = 1'b1;
                  else void'(m_stk.pop_back());
            3'd2, 3'd3, 3'd4, 3'd5: begin
                if (m_stk.size() < 2) m_err = 1'b1;
                else begin
                    y = m_stk.pop_back();
                    x = m_stk.pop_back();
                    m_stk.push_back(f_alu(op, x, y, dz));
                    if (dz) m_err = 1'b1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, output int stall);
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_addr = a;
        @(negedge clk);
        instr_valid = 1'b0;
        stall = 0;
        while (!instr_ready) begin stall++; @(negedge clk); end
    endtask

    task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input string req);
        int st;
        model(op, a);
        issue(op, a, st);
        cmp_state(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        m_stk.delete();
        m_err = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st;
        logic [DW-1:0] sv;
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << AW); i++) mem[i] <= DW'($urandom);
        mem[10] <= 16'd6; mem[11] <= 16'd5; mem[12] <= 16'd3;
        mem[13] <= 16'd4; mem[14] <= 16'd2; mem[15] <= 16'd1;
        mem[20] <= 16'd9; mem[21] <= 16'd4; mem[22] <= 16'd0;
        mem[23] <= 16'd300; mem[24] <= 16'd500;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(depth == 0, "R1", "depth", depth, 0);
        chk(err == 0, "R1", "err", err, 0);
        chk(instr_ready == 1, "R1", "ready", instr_ready, 1);
        chk(mem_req == 0, "R1", "mem_req", mem_req, 0);

        // R2 load with stall count
        model(3'd0, 8'd20);
        issue(3'd0, 8'd20, st);
        chk(st == 2, "R2", "load stall", st, 2);
        cmp_state("R2");
        run(3'd0, 8'd21, "R2");
        // R4 subtract order: 9 - 4
        run(3'd3, 8'd0, "R4");
        chk(top_data == 16'd5, "R4", "sub", top_data, 5);
        run(3'd0, 8'd21, "R4");
        run(3'd2, 8'd0, "R4");
        run(3'd0, 8'd23, "R4");
        run(3'd0, 8'd24, "R4");
        run(3'd4, 8'd0, "R4");
        chk(top_data == 16'((300 * 500) & 16'hFFFF), "R4", "mul wrap", top_data, (300*500) & 16'hFFFF);
        // R9 unused opcodes
        run(3'd6, 8'd0, "R9");
        run(3'd7, 8'd0, "R9");
        // R3 store
        sv = top_data;
        model(3'd1, 8'd40);
        issue(3'd1, 8'd40, st);
        chk(st == 1, "R3", "store stall", st, 1);
        cmp_state("R3");
        chk(mem[40] == sv, "R3", "stored word", mem[40], sv);
        // R5 divide 9 / 4
        run(3'd0, 8'd20, "R5");
        run(3'd0, 8'd21, "R5");
        run(3'd5, 8'd0, "R5");
        chk(top_data == 16'd2, "R5", "quotient", top_data, 2);
        chk(err == 0, "R5", "err clean", err, 0);

        // R11 instruction held during load stall is ignored
        do_reset();
        run(3'd0, 8'd20, "R11");
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'd0; instr_addr = 8'd21;
        @(negedge clk);
        instr_op = 3'd2;
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b0;
        model(3'd0, 8'd21);
        cmp_state("R11");

        // R5 divide by zero: result and flag on the same edge
        do_reset();
        run(3'd0, 8'd20, "R5");
        run(3'd0, 8'd22, "R5");
        run(3'd5, 8'd0, "R5");
        chk(top_data == 16'hFFFF, "R5", "div0 result", top_data, 16'hFFFF);
        chk(err == 1, "R5", "div0 err", err, 1);
        // R8 flag stays through good work
        run(3'd0, 8'd21, "R8");
        run(3'd2, 8'd0, "R8");
        chk(err == 1, "R8", "sticky", err, 1);

        // R7 underflow
        do_reset();
        run(3'd2, 8'd0, "R7");
        do_reset();
        run(3'd1, 8'd50, "R7");
        do_reset();
        run(3'd0, 8'd20, "R7");
        run(3'd5, 8'd0, "R7");

        // R6 overflow
        do_reset();
        for (int i = 0; i < DEPTH; i++) run(3'd0, AW'(30 + i), "R6");
        model(3'd0, 8'd60);
        issue(3'd0, 8'd60, st);
        chk(st == 0, "R6", "no mem access", st, 0);
        cmp_state("R6");

        // R10 postfix expression a b c d * + * e f + /
        do_reset();
        run(3'd0, 8'd10, "R10"); run(3'd0, 8'd11, "R10");
        run(3'd0, 8'd12, "R10"); run(3'd0, 8'd13, "R10");
        run(3'd4, 8'd0, "R10");  run(3'd2, 8'd0, "R10");
        run(3'd4, 8'd0, "R10");  run(3'd0, 8'd14, "R10");
        run(3'd0, 8'd15, "R10"); run(3'd2, 8'd0, "R10");
        run(3'd5, 8'd0, "R10");
        chk(depth == 1, "R10", "final depth", depth, 1);
        chk(top_data == 16'd34, "R10", "final value", top_data, 34);

        // random mix, loads weighted up
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            for (int k = 0; k < 150; k++) begin
                logic [2:0] op;
                int unsigned r;
                r = $urandom_range(0, 9);
                op = (r >= 8) ? 3'd0 : 3'(r);
                run(op, AW'($urandom_range(64, 255)), "R4");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule